// File: doc/BRIEF.md
# Exception entry and return-PC selector

This block decides, once per cycle, whether a pending event (a general exception, a maskable interrupt, a non-maskable interrupt or a user break) is taken by a small 32-bit core. When an event is taken, the block saves the return PC and the status bits. It raises the mode, bank and block bits and redirects the PC to the vector base plus a per-class offset. The saved PC is chosen from the pipeline PCs that the core presents: current, next, delay slot, branch target and the delayed branch ahead of the slot. The choice depends on whether the event re-executes or completes, whether the instruction sits in a delay slot, and how a conditional delayed branch resolved. While the block bit is set, a general exception does not enter normally. The PC is forced to the fixed restart address and the saved context is left untouched.

Events arrive on a valid/ready channel. The block drops `evt_ready` only in a cycle where `rte_i` is high, because a return takes priority. A source under back-pressure must hold its request. Every handshake is consumed in that cycle, whether the event is taken, forced to the restart address or ignored. A level-type source that is ignored must present its request again. The status and vector-base load inputs stand in for the core's register-write path.

Top module: `exc_entry_ctrl`

## Requirements
- R1: After reset `pc_o` is 0xA0000000, `sr_o` is 7'h7F, and `vbr_o`, `spc_o`, `ssr_o` and `event_o` are 0. `taken_o` and `redirect_o` are 0. `sr_o` packs {md[6], rb[5], bl[4], imask[3:0]}.
- R2: A maskable interrupt (`evt_kind`=1) is taken only when the block bit is 0 or `sleep_i` is 1, and only when `evt_level` is strictly greater than the imask field. Taking it writes `evt_level` into imask.
- R3: An NMI (`evt_kind`=2) is taken when the block bit is 0 or `nmi_en_i` is 1. Otherwise it is ignored and leaves all state unchanged.
- R4: A user break (`evt_kind`=3) with the block bit at 1 is ignored. No taken pulse follows and the PC and saved registers stay unchanged.
- R5: A general exception (`evt_kind`=0) with the block bit at 1 sets `pc_o` to 0xA0000000 in the next cycle. `spc_o`, `ssr_o`, `event_o` and `sr_o` are unchanged and `taken_o` stays 0.
- R6: For a re-executing event (`evt_reexec`=1, kinds 0 and 3 only), the saved PC is `pc_cur` when the instruction is not in a slot. In a slot it is `pc_prior_br`. It is `pc_slot` when the slot belongs to a conditional branch (`cond_br_i`) whose condition failed (`cond_taken_i`=0).
- R7: For a completed event, and for every interrupt or NMI, the saved PC is `pc_next`. When `cond_br_i` is 1 it is instead `pc_target` if `cond_taken_i` is 1 and `pc_slot` if not.
- R8: On a taken event, the next cycle shows: `spc_o` set to the saved PC, `ssr_o` set to the old `sr_o`, `event_o` set to `evt_code`, and md, rb and bl all set to 1. `pc_o` is the old `vbr_o` plus 0x100 for kinds 0 and 3, or plus 0x600 for kinds 1 and 2. `taken_o` is 1 for that one cycle.
- R9: With `rte_i` high, the next cycle shows `sr_o` equal to the old `ssr_o` and `pc_o` equal to the old `spc_o`. `evt_ready` is 0 in that cycle and no event is consumed.
- R10: `sr_load` writes `sr_value` into the status only in a cycle with no return and no taken or forced event. `vbr_load` always writes `vbr_value`, and an entry in the same cycle still uses the old base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_valid | input | 1 | Event request valid |
| evt_ready | output | 1 | Event channel ready (low during return) |
| evt_kind | input | 2 | 0 general, 1 interrupt, 2 NMI, 3 user break |
| evt_reexec | input | 1 | Event re-executes the instruction |
| evt_level | input | 4 | Interrupt level |
| evt_code | input | 12 | Event code to record |
| in_slot_i | input | 1 | Instruction sits in a delay slot |
| cond_br_i | input | 1 | Conditional delayed branch involved |
| cond_taken_i | input | 1 | Its condition was true |
| pc_cur | input | 32 | PC of the instruction |
| pc_next | input | 32 | PC of the following instruction |
| pc_slot | input | 32 | Delay-slot PC |
| pc_target | input | 32 | Branch target PC |
| pc_prior_br | input | 32 | PC of the delayed branch ahead of the slot |
| sleep_i | input | 1 | Core in sleep or standby |
| nmi_en_i | input | 1 | NMI accepted despite block bit |
| rte_i | input | 1 | Return from exception |
| sr_load | input | 1 | Status write strobe |
| sr_value | input | 7 | Status write data |
| vbr_load | input | 1 | Vector base write strobe |
| vbr_value | input | 32 | Vector base write data |
| pc_o | output | 32 | Program counter |
| redirect_o | output | 1 | PC was redirected last cycle |
| taken_o | output | 1 | An event was taken last cycle |
| sr_o | output | 7 | Status {md, rb, bl, imask} |
| spc_o | output | 32 | Saved PC |
| ssr_o | output | 7 | Saved status |
| event_o | output | 12 | Recorded event code |
| vbr_o | output | 32 | Vector base |

## Verification
The bench covers every combination of slot position, conditional branch and branch outcome for both re-executing and completed events. A wrong saved-PC mux would return to the branch instead of the slot, or skip an instruction. Interrupt levels equal to the mask are driven to catch a `>=` compare that takes an interrupt it should hold. Sleep with the block bit set is driven so that a missing wake-up path shows up as a lost interrupt. Exceptions under the block bit are driven because a design that entered normally there would overwrite the saved PC and status. Returns that collide with requests and loads expose a wrong priority, which would corrupt the restored status.

// File: rtl/exc_pkg.sv
package exc_pkg;
  typedef enum logic [1:0] {
    EV_GEN = 2'd0,
    EV_IRQ = 2'd1,
    EV_NMI = 2'd2,
    EV_BRK = 2'd3
  } ev_kind_e;

  typedef struct packed {
    logic       md;
    logic       rb;
    logic       bl;
    logic [3:0] imask;
  } sr_t;

  localparam int SR_W = 7;
  localparam sr_t SR_RESET = '{md: 1'b1, rb: 1'b1, bl: 1'b1, imask: 4'hF};
endpackage

// File: rtl/exc_accept.sv
module exc_accept
  import exc_pkg::*;
(
  input  logic       fire,
  input  ev_kind_e   kind,
  input  logic [3:0] level,
  input  sr_t        sr,
  input  logic       sleep_i,
  input  logic       nmi_en_i,
  output logic       accept,
  output logic       force_restart
);
  logic lvl_ok;

  assign lvl_ok = level > sr.imask;

  always_comb begin
    accept        = 1'b0;
    force_restart = 1'b0;
    if (fire) begin
      unique case (kind)
        EV_GEN: begin
          accept        = !sr.bl;
          force_restart = sr.bl;
        end
        EV_IRQ: accept = (!sr.bl || sleep_i) && lvl_ok;
        EV_NMI: accept = !sr.bl || nmi_en_i;
        EV_BRK: accept = !sr.bl;
        default: accept = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/exc_spc_sel.sv
module exc_spc_sel #(
  parameter int XLEN = 32
) (
  input  logic            reexec,
  input  logic            in_slot,
  input  logic            cond_br,
  input  logic            cond_taken,
  input  logic [XLEN-1:0] pc_cur,
  input  logic [XLEN-1:0] pc_next,
  input  logic [XLEN-1:0] pc_slot,
  input  logic [XLEN-1:0] pc_target,
  input  logic [XLEN-1:0] pc_prior_br,
  output logic [XLEN-1:0] saved_pc
);
  logic br_failed;

  assign br_failed = cond_br && !cond_taken;

  always_comb begin
    if (reexec) begin
      if (in_slot) saved_pc = br_failed ? pc_slot : pc_prior_br;
      else         saved_pc = pc_cur;
    end else begin
      if (cond_br) saved_pc = cond_taken ? pc_target : pc_slot;
      else         saved_pc = pc_next;
    end
  end
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
  import exc_pkg::*;
#(
  parameter int          XLEN     = 32,
  parameter int          CODE_W   = 12,
  parameter logic [31:0] RESET_PC = 32'hA000_0000,
  parameter logic [31:0] OFS_GEN  = 32'h0000_0100,
  parameter logic [31:0] OFS_INT  = 32'h0000_0600
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt_valid,
  output logic              evt_ready,
  input  logic [1:0]        evt_kind,
  input  logic              evt_reexec,
  input  logic [3:0]        evt_level,
  input  logic [CODE_W-1:0] evt_code,
  input  logic              in_slot_i,
  input  logic              cond_br_i,
  input  logic              cond_taken_i,
  input  logic [XLEN-1:0]   pc_cur,
  input  logic [XLEN-1:0]   pc_next,
  input  logic [XLEN-1:0]   pc_slot,
  input  logic [XLEN-1:0]   pc_target,
  input  logic [XLEN-1:0]   pc_prior_br,
  input  logic              sleep_i,
  input  logic              nmi_en_i,
  input  logic              rte_i,
  input  logic              sr_load,
  input  logic [6:0]        sr_value,
  input  logic              vbr_load,
  input  logic [XLEN-1:0]   vbr_value,
  output logic [XLEN-1:0]   pc_o,
  output logic              redirect_o,
  output logic              taken_o,
  output logic [6:0]        sr_o,
  output logic [XLEN-1:0]   spc_o,
  output logic [6:0]        ssr_o,
  output logic [CODE_W-1:0] event_o,
  output logic [XLEN-1:0]   vbr_o
);
  localparam logic [XLEN-1:0] RST_PC_X  = XLEN'(RESET_PC);
  localparam logic [XLEN-1:0] OFS_GEN_X = XLEN'(OFS_GEN);
  localparam logic [XLEN-1:0] OFS_INT_X = XLEN'(OFS_INT);

  sr_t             sr_q, ssr_q;
  logic [XLEN-1:0] pc_q, spc_q, vbr_q;
  logic [CODE_W-1:0] evt_q;
  logic            taken_q, redir_q;

  ev_kind_e        kind;
  logic            fire, accept, force_restart, is_int, reexec_eff;
  logic [XLEN-1:0] saved_pc, vec_pc;
  sr_t             sr_entry;

  assign kind       = ev_kind_e'(evt_kind);
  assign evt_ready  = !rte_i;
  assign fire       = evt_valid && evt_ready;
  assign is_int     = (kind == EV_IRQ) || (kind == EV_NMI);
  assign reexec_eff = evt_reexec && !is_int;
  assign vec_pc     = vbr_q + (is_int ? OFS_INT_X : OFS_GEN_X);

  exc_accept u_accept (
    .fire          (fire),
    .kind          (kind),
    .level         (evt_level),
    .sr            (sr_q),
    .sleep_i       (sleep_i),
    .nmi_en_i      (nmi_en_i),
    .accept        (accept),
    .force_restart (force_restart)
  );

  exc_spc_sel #(.XLEN(XLEN)) u_spc_sel (
    .reexec      (reexec_eff),
    .in_slot     (in_slot_i),
    .cond_br     (cond_br_i),
    .cond_taken  (cond_taken_i),
    .pc_cur      (pc_cur),
    .pc_next     (pc_next),
    .pc_slot     (pc_slot),
    .pc_target   (pc_target),
    .pc_prior_br (pc_prior_br),
    .saved_pc    (saved_pc)
  );

  always_comb begin
    sr_entry    = sr_q;
    sr_entry.md = 1'b1;
    sr_entry.rb = 1'b1;
    sr_entry.bl = 1'b1;
    if (kind == EV_IRQ) sr_entry.imask = evt_level;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q    <= RST_PC_X;
      sr_q    <= SR_RESET;
      ssr_q   <= '0;
      spc_q   <= '0;
      evt_q   <= '0;
      vbr_q   <= '0;
      taken_q <= 1'b0;
      redir_q <= 1'b0;
    end else begin
      taken_q <= 1'b0;
      redir_q <= 1'b0;
      if (rte_i) begin
        sr_q    <= ssr_q;
        pc_q    <= spc_q;
        redir_q <= 1'b1;
      end else if (accept) begin
        spc_q   <= saved_pc;
        ssr_q   <= sr_q;
        evt_q   <= evt_code;
        sr_q    <= sr_entry;
        pc_q    <= vec_pc;
        taken_q <= 1'b1;
        redir_q <= 1'b1;
      end else if (force_restart) begin
        pc_q    <= RST_PC_X;
        redir_q <= 1'b1;
      end else if (sr_load) begin
        sr_q <= sr_t'(sr_value);
      end
      if (vbr_load) vbr_q <= vbr_value;
    end
  end

  assign pc_o       = pc_q;
  assign sr_o       = sr_q;
  assign ssr_o      = ssr_q;
  assign spc_o      = spc_q;
  assign event_o    = evt_q;
  assign vbr_o      = vbr_q;
  assign taken_o    = taken_q;
  assign redirect_o = redir_q;
endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk #(
  parameter int XLEN   = 32,
  parameter int CODE_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              evt_valid,
  input logic              evt_ready,
  input logic [1:0]        evt_kind,
  input logic [3:0]        evt_level,
  input logic              nmi_en_i,
  input logic              rte_i,
  input logic [XLEN-1:0]   pc_o,
  input logic              taken_o,
  input logic [6:0]        sr_o,
  input logic [XLEN-1:0]   spc_o,
  input logic [6:0]        ssr_o,
  input logic [CODE_W-1:0] event_o
);
  logic fire;
  assign fire = evt_valid && evt_ready;

  AST_IRQ_LEVEL_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
    (taken_o && $past(evt_kind) == 2'd1) |->
      (sr_o[3:0] == $past(evt_level) && $past(evt_level) > $past(sr_o[3:0]))); // R2

  AST_NMI_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && evt_kind == 2'd2 && nmi_en_i) |=> taken_o); // R3

  AST_BRK_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && evt_kind == 2'd3 && sr_o[4]) |=>
      (!taken_o && spc_o == $past(spc_o) && pc_o == $past(pc_o))); // R4

  AST_BLOCKED_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && evt_kind == 2'd0 && sr_o[4]) |=>
      (pc_o == 32'hA000_0000 && spc_o == $past(spc_o) && ssr_o == $past(ssr_o)
       && event_o == $past(event_o) && !taken_o)); // R5

  AST_ENTRY_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    taken_o |-> (sr_o[6:4] == 3'b111)); // R8

  AST_RETURN_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
    rte_i |=> (pc_o == $past(spc_o) && sr_o == $past(ssr_o))); // R9
endmodule

bind exc_entry_ctrl exc_entry_chk #(.XLEN(XLEN), .CODE_W(CODE_W)) u_chk (.*);

// File: tb/sim_exc_entry_ctrl.sv
module sim_exc_entry_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        evt_valid, evt_ready, evt_reexec, in_slot_i, cond_br_i, cond_taken_i;
  logic [1:0]  evt_kind;
  logic [3:0]  evt_level;
  logic [11:0] evt_code;
  logic [31:0] pc_cur, pc_next, pc_slot, pc_target, pc_prior_br, vbr_value;
  logic        sleep_i, nmi_en_i, rte_i, sr_load, vbr_load;
  logic [6:0]  sr_value;
  logic [31:0] pc_o, spc_o, vbr_o;
  logic        redirect_o, taken_o;
  logic [6:0]  sr_o, ssr_o;
  logic [11:0] event_o;

  exc_entry_ctrl u0 (.*);

  int n_chk = 0, n_fail = 0;
  logic [31:0] m_pc, m_spc, m_vbr;
  logic [6:0]  m_sr, m_ssr;
  logic [11:0] m_evt;
  logic        m_taken;
  string       tag, tag_spc;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_spc(input bit reexec);
    if (reexec && in_slot_i)
      return (cond_br_i && !cond_taken_i) ? pc_slot : pc_prior_br;
    if (reexec) return pc_cur;
    if (!cond_br_i) return pc_next;
    return cond_taken_i ? pc_target : pc_slot;
  endfunction

  task automatic model_step();
    bit bl, acc, interrupt, rx;
    bl = m_sr[4];
    interrupt = (evt_kind == 2'd1) || (evt_kind == 2'd2);
    rx = evt_reexec && !interrupt;
    m_taken = 1'b0;
    tag = "R10";
    tag_spc = "R10";
    acc = 1'b0;
    if (rte_i) begin
      tag = "R9"; tag_spc = "R9";
      m_pc = m_spc;
      m_sr = m_ssr;
    end else begin
      if (evt_valid) begin
        case (evt_kind)
          2'd0: begin acc = !bl; tag = bl ? "R5" : "R8"; end
          2'd1: begin acc = (!bl || sleep_i) && (evt_level > m_sr[3:0]); tag = "R2"; end
          2'd2: begin acc = !bl || nmi_en_i; tag = "R3"; end
          default: begin acc = !bl; tag = bl ? "R4" : "R8"; end
        endcase
        tag_spc = tag;
      end
      if (acc) begin
        tag_spc = rx ? "R6" : "R7";
        m_spc = exp_spc(rx);
        m_ssr = m_sr;
        m_evt = evt_code;
        m_sr[6:4] = 3'b111;
        if (evt_kind == 2'd1) m_sr[3:0] = evt_level;
        m_pc = m_vbr + (interrupt ? 32'h600 : 32'h100);
        m_taken = 1'b1;
      end else if (evt_valid && evt_kind == 2'd0 && bl) begin
        m_pc = 32'hA000_0000;
      end else if (sr_load) begin
        m_sr = sr_value;
      end
    end
    if (vbr_load) m_vbr = vbr_value;
  endtask

  task automatic run_cycle();
    #0.5;
    chk(evt_ready == !rte_i, "R9", "evt_ready", 32'(evt_ready), 32'(!rte_i));
    model_step();
    @(negedge clk);
    chk(pc_o == m_pc, tag, "pc", pc_o, m_pc);
    chk(sr_o == m_sr, tag, "sr", 32'(sr_o), 32'(m_sr));
    chk(spc_o == m_spc, tag_spc, "spc", spc_o, m_spc);
    chk(ssr_o == m_ssr, tag, "ssr", 32'(ssr_o), 32'(m_ssr));
    chk(event_o == m_evt, tag, "event", 32'(event_o), 32'(m_evt));
    chk(taken_o == m_taken, tag, "taken", 32'(taken_o), 32'(m_taken));
    chk(vbr_o == m_vbr, "R10", "vbr", vbr_o, m_vbr);
  endtask

  task automatic idle();
    evt_valid = 0; evt_kind = 0; evt_reexec = 0; evt_level = 0; evt_code = 0;
    in_slot_i = 0; cond_br_i = 0; cond_taken_i = 0; sleep_i = 0; nmi_en_i = 0;
    rte_i = 0; sr_load = 0; sr_value = 0; vbr_load = 0; vbr_value = 0;
    pc_cur = 32'h1000; pc_next = 32'h1002; pc_slot = 32'h1004;
    pc_target = 32'h2000; pc_prior_br = 32'h0FFE;
  endtask

  task automatic randomize_inputs();
    evt_valid = ($urandom % 10) < 6;
    evt_kind = 2'($urandom);
    evt_reexec = 1'($urandom);
    evt_level = 4'($urandom);
    evt_code = 12'($urandom);
    in_slot_i = 1'($urandom);
    cond_br_i = 1'($urandom);
    cond_taken_i = 1'($urandom);
    sleep_i = ($urandom % 4) == 0;
    nmi_en_i = 1'($urandom);
    rte_i = ($urandom % 8) == 0;
    sr_load = ($urandom % 3) == 0;
    sr_value = 7'($urandom);
    vbr_load = ($urandom % 16) == 0;
    vbr_value = {20'($urandom), 12'h000};
    pc_cur = $urandom; pc_next = $urandom; pc_slot = $urandom;
    pc_target = $urandom; pc_prior_br = $urandom;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    idle();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk(pc_o == 32'hA000_0000, "R1", "pc", pc_o, 32'hA000_0000);
    chk(sr_o == 7'h7F, "R1", "sr", 32'(sr_o), 32'h7F);
    chk(vbr_o == 0 && spc_o == 0 && ssr_o == 0 && event_o == 0, "R1", "regs",
        vbr_o | spc_o | 32'(ssr_o) | 32'(event_o), 0);
    chk(!taken_o && !redirect_o, "R1", "pulses", 32'({taken_o, redirect_o}), 0);
    m_pc = 32'hA000_0000; m_sr = 7'h7F; m_vbr = 0; m_spc = 0; m_ssr = 0; m_evt = 0;

    // R4 user break under block bit
    idle(); evt_valid = 1; evt_kind = 2'd3; run_cycle();
    // R5 general exception under block bit
    idle(); evt_valid = 1; evt_kind = 2'd0; evt_code = 12'h0AB; run_cycle();
    // R2 sleep wakes with block bit set, level F vs mask F not taken
    idle(); evt_valid = 1; evt_kind = 2'd1; evt_level = 4'hF; sleep_i = 1; run_cycle();
    // R10 lower mask, keep bl=1, set base
    idle(); sr_load = 1; sr_value = 7'h73; vbr_load = 1; vbr_value = 32'h8000_0000; run_cycle();
    // R2 equal level not taken, then higher level taken in sleep
    idle(); evt_valid = 1; evt_kind = 2'd1; evt_level = 4'h3; sleep_i = 1; run_cycle();
    idle(); evt_valid = 1; evt_kind = 2'd1; evt_level = 4'h4; sleep_i = 1; cond_br_i = 1;
    cond_taken_i = 1; run_cycle();
    // R3 NMI blocked without enable, taken with enable
    idle(); evt_valid = 1; evt_kind = 2'd2; run_cycle();
    idle(); evt_valid = 1; evt_kind = 2'd2; nmi_en_i = 1; run_cycle();
    // R9 return collides with request
    idle(); rte_i = 1; evt_valid = 1; evt_kind = 2'd2; nmi_en_i = 1; run_cycle();
    // R6 and R7 slot/branch combinations with bl cleared
    for (int c = 0; c < 16; c++) begin
      idle(); sr_load = 1; sr_value = 7'h0F; run_cycle();
      idle(); evt_valid = 1; evt_kind = 2'd0; evt_reexec = c[0]; in_slot_i = c[1];
      cond_br_i = c[2]; cond_taken_i = c[3]; evt_code = 12'(c); run_cycle();
    end

    for (int i = 0; i < 4000; i++) begin
      randomize_inputs();
      run_cycle();
    end
    idle(); run_cycle();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule